// File: doc/BRIEF.md
# Packet Ready Tracker for a Multi-Queue Buffer

This block sits beside the storage of a multi-queue buffer and watches the marker bits that travel in the two top bits of every 36-bit word. On the write side it finds where packets begin and end in each queue. It keeps a count, per queue, of packets that have been fully written and not yet fully read. The block does not hold the data words themselves.

From these counts it drives a ready flag for the queue that the read port currently selects, and a vector with one ready bit per queue. When packet mode is active, that vector replaces the almost-empty status on the status bus. When packet mode is not active, the status bus carries the almost-empty input unchanged. Packet mode is honoured only when both data ports are configured for the full 36-bit width.

A write of an end marker closes the open packet on that queue and counts it. A read of an end marker retires one packet. A partial reset of one queue clears that queue's count and its open-packet state.

Top module: `pkt_ready_tracker`

## Requirements
- R1: Packet mode is in effect only while `modeReq`, `wrPortWide` and `rdPortWide` are all 1. Outside packet mode no count or open state changes on a write or a read, `pktReady` and `readyVec` are 0, and `statusBus` equals `aeIn`.
- R2: Marker encoding: `wrMark[1]` is the end marker (word bit 35) and `wrMark[0]` is the start marker (word bit 34). `rdEop` is bit 35 of the word being read.
- R3: A written word with the start marker opens a packet on its queue. A second start marker while a packet is already open restarts that open packet and does not count it.
- R4: A written word with the end marker completes a packet, and increments that queue's count, when a packet is open on that queue or when the same word also carries the start marker. Either way it closes the open packet.
- R5: A written end marker on a queue with no open packet, and with no start marker in the same word, leaves the count unchanged.
- R6: A read with `rdEop`=1 decrements the count of queue `rdQ`.
- R7: A read end marker on a queue whose count is 0 is ignored, so the count never wraps below zero.
- R8: When a write completes a packet and a read retires one on the same queue in the same cycle, a non-zero count is left unchanged.
- R9: Each count saturates at 2^CNT_W-1. A completion beyond that value is dropped.
- R10: `prstEn` with `prstQ` clears that queue's count and its open-packet state. This takes precedence over a write or read to the same queue in the same cycle.
- R11: `readyVec[i]` is 1 when queue i's count is non-zero, and `pktReady` equals `readyVec[rdQ]`. Both reflect a count change from the clock edge that records it.
- R12: In packet mode, `statusBus` equals `readyVec`.
- R13: While `rstN` is low, all counts and open states are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rstN | input | 1 | Asynchronous active-low reset |
| modeReq | input | 1 | Packet mode requested |
| wrPortWide | input | 1 | Write port configured 36 bits wide |
| rdPortWide | input | 1 | Read port configured 36 bits wide |
| wrEn | input | 1 | A word is written this cycle |
| wrQ | input | QW | Queue addressed by the write |
| wrMark | input | 2 | Write markers: bit 1 end, bit 0 start |
| rdEn | input | 1 | A word is read this cycle |
| rdQ | input | QW | Queue selected on the read port |
| rdEop | input | 1 | End marker of the word being read |
| prstEn | input | 1 | Partial reset strobe |
| prstQ | input | QW | Queue to partially reset |
| aeIn | input | NUM_QUEUES | Almost-empty status per queue |
| pktReady | output | 1 | Packet ready for the read-selected queue |
| readyVec | output | NUM_QUEUES | Packet ready bit per queue |
| statusBus | output | NUM_QUEUES | Packet-ready bits in packet mode, else `aeIn` |

## Verification
The bench builds the block with NUM_QUEUES=16 and CNT_W=2. With this count width the saturation point is 3, so five back-to-back single-word packets followed by a few reads show that the count holds at its limit and does not wrap. Sixteen queues let the stimulus spread activity over widely separated index values. This checks that one queue's strobes never reach a neighbour's count, and that the full 16-bit vector carries the ready bits to the status bus.

// File: rtl/pkt_ready_pkg.sv
package pkt_ready_pkg;
  // Per-queue command from control to the count datapath
  typedef struct packed {
    logic inc;   // a packet finished on the write side
    logic dec;   // a packet end left on the read side
    logic clr;   // partial reset of this queue
  } qStrobe_t;
endpackage

// File: rtl/pkt_ready_ctrl.sv
module pkt_ready_ctrl
  import pkt_ready_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeReq,
  input  logic                wrPortWide,
  input  logic                rdPortWide,
  input  logic                wrEn,
  input  logic [QW-1:0]       wrQ,
  input  logic [1:0]          wrMark,
  input  logic                rdEn,
  input  logic [QW-1:0]       rdQ,
  input  logic                rdEop,
  input  logic                prstEn,
  input  logic [QW-1:0]       prstQ,
  output logic                modeOn,
  output qStrobe_t [NUM_QUEUES-1:0] strobes
);
  localparam int EOP_IDX = 1;
  localparam int SOP_IDX = 0;

  logic [NUM_QUEUES-1:0] openQ;
  logic wrSop, wrEopBit;

  assign modeOn   = modeReq & wrPortWide & rdPortWide;
  assign wrSop    = wrMark[SOP_IDX];
  assign wrEopBit = wrMark[EOP_IDX];

  for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_q
    logic wrHit, rdHit, prHit;
    assign wrHit = wrEn   && (wrQ   == QW'(i));
    assign rdHit = rdEn   && (rdQ   == QW'(i));
    assign prHit = prstEn && (prstQ == QW'(i));

    always_comb begin
      strobes[i].clr = prHit;
      strobes[i].inc = modeOn && wrHit && wrEopBit && (openQ[i] || wrSop) && !prHit;
      strobes[i].dec = modeOn && rdHit && rdEop && !prHit;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ[i] <= 1'b0;
      end else if (prHit) begin
        openQ[i] <= 1'b0;
      end else if (modeOn && wrHit) begin
        if (wrEopBit)   openQ[i] <= 1'b0;
        else if (wrSop) openQ[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_ready_dp.sv
module pkt_ready_dp
  import pkt_ready_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int CNT_W = 8,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      modeOn,
  input  qStrobe_t [NUM_QUEUES-1:0] strobes,
  input  logic [QW-1:0]             rdQ,
  input  logic [NUM_QUEUES-1:0]     aeIn,
  output logic                      pktReady,
  output logic [NUM_QUEUES-1:0]     readyVec,
  output logic [NUM_QUEUES-1:0]     statusBus
);
  logic [NUM_QUEUES-1:0] nonZero;

  for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic decOk, incOk;
    assign decOk = strobes[i].dec && (cnt != '0);
    assign incOk = strobes[i].inc && ((cnt != CNT_MAX) || decOk);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cnt <= '0;
      else if (strobes[i].clr) cnt <= '0;
      else if (incOk && !decOk) cnt <= cnt + 1'b1;
      else if (decOk && !incOk) cnt <= cnt - 1'b1;
    end
    assign nonZero[i] = (cnt != '0);
  end

  assign readyVec  = modeOn ? nonZero : '0;
  assign statusBus = modeOn ? readyVec : aeIn;
  assign pktReady  = (int'(rdQ) < NUM_QUEUES) ? readyVec[rdQ] : 1'b0;
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker
  import pkt_ready_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int CNT_W = 8,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeReq,
  input  logic                  wrPortWide,
  input  logic                  rdPortWide,
  input  logic                  wrEn,
  input  logic [QW-1:0]         wrQ,
  input  logic [1:0]            wrMark,
  input  logic                  rdEn,
  input  logic [QW-1:0]         rdQ,
  input  logic                  rdEop,
  input  logic                  prstEn,
  input  logic [QW-1:0]         prstQ,
  input  logic [NUM_QUEUES-1:0] aeIn,
  output logic                  pktReady,
  output logic [NUM_QUEUES-1:0] readyVec,
  output logic [NUM_QUEUES-1:0] statusBus
);
  logic modeOn;
  qStrobe_t [NUM_QUEUES-1:0] strobes;

  pkt_ready_ctrl #(.NUM_QUEUES(NUM_QUEUES)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .wrPortWide(wrPortWide),
    .rdPortWide(rdPortWide), .wrEn(wrEn), .wrQ(wrQ), .wrMark(wrMark),
    .rdEn(rdEn), .rdQ(rdQ), .rdEop(rdEop), .prstEn(prstEn), .prstQ(prstQ),
    .modeOn(modeOn), .strobes(strobes)
  );

  pkt_ready_dp #(.NUM_QUEUES(NUM_QUEUES), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .modeOn(modeOn), .strobes(strobes), .rdQ(rdQ),
    .aeIn(aeIn), .pktReady(pktReady), .readyVec(readyVec), .statusBus(statusBus)
  );
endmodule

// File: rtl/pkt_ready_tracker_chk.sv
module pkt_ready_tracker_chk #(
  parameter int NUM_QUEUES = 16,
  localparam int QW = $clog2(NUM_QUEUES)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  modeReq,
  input logic                  wrPortWide,
  input logic                  rdPortWide,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [QW-1:0]         rdQ,
  input logic                  prstEn,
  input logic [QW-1:0]         prstQ,
  input logic [NUM_QUEUES-1:0] aeIn,
  input logic                  pktReady,
  input logic [NUM_QUEUES-1:0] readyVec,
  input logic [NUM_QUEUES-1:0] statusBus
);
  logic modeNow;
  assign modeNow = modeReq && wrPortWide && rdPortWide;

  a_r1_mode_off_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !modeNow |-> (statusBus == aeIn && readyVec == '0 && !pktReady));

  a_r10_prst_clears: assert property (@(posedge clk) disable iff (!rstN)
    prstEn |=> (!readyVec[$past(prstQ)]));

  a_r6_drop_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow && !prstEn && !rdEn) |=>
      (!modeNow || ((readyVec & $past(readyVec)) == $past(readyVec))));

  a_r4_rise_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow && !wrEn) |=> (!modeNow || ((readyVec & ~$past(readyVec)) == '0)));

  a_r11_flag_select: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdQ) < NUM_QUEUES) |-> (pktReady == readyVec[rdQ]));

  a_r12_bus_in_mode: assert property (@(posedge clk) disable iff (!rstN)
    modeNow |-> (statusBus == readyVec));
endmodule

bind pkt_ready_tracker pkt_ready_tracker_chk #(.NUM_QUEUES(NUM_QUEUES)) chk_i (
  .clk(clk), .rstN(rstN), .modeReq(modeReq), .wrPortWide(wrPortWide),
  .rdPortWide(rdPortWide), .wrEn(wrEn), .rdEn(rdEn), .rdQ(rdQ),
  .prstEn(prstEn), .prstQ(prstQ), .aeIn(aeIn), .pktReady(pktReady),
  .readyVec(readyVec), .statusBus(statusBus)
);

// File: tb/pkt_ready_tracker_tb_top.sv
module pkt_ready_tracker_tb_top;
  localparam int NQ = 16;
  localparam int QW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeReq = 1'b1, wrPortWide = 1'b1, rdPortWide = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0, rdEop = 1'b0, prstEn = 1'b0;
  logic [QW-1:0] wrQ = '0, rdQ = '0, prstQ = '0;
  logic [1:0] wrMark = '0;
  logic [NQ-1:0] aeIn = 16'hA5C3;
  logic pktReady;
  logic [NQ-1:0] readyVec, statusBus;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pkt_ready_tracker #(.NUM_QUEUES(NQ), .CNT_W(2)) dut_i (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .wrPortWide(wrPortWide),
    .rdPortWide(rdPortWide), .wrEn(wrEn), .wrQ(wrQ), .wrMark(wrMark),
    .rdEn(rdEn), .rdQ(rdQ), .rdEop(rdEop), .prstEn(prstEn), .prstQ(prstQ),
    .aeIn(aeIn), .pktReady(pktReady), .readyVec(readyVec), .statusBus(statusBus)
  );

  typedef struct packed {
    logic          wEn;
    logic [QW-1:0] wQ;
    logic [1:0]    wMk;   // bit 1 end, bit 0 start
    logic          rEn;
    logic [QW-1:0] rQ;
    logic          rEop;
    logic [NQ-1:0] expVec;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TABLE [NV] = '{
    '{1'b1, 4'd3, 2'b01, 1'b0, 4'd3, 1'b0, 16'h0000}, // R3 open q3
    '{1'b1, 4'd3, 2'b00, 1'b0, 4'd3, 1'b0, 16'h0000}, // R3 middle word
    '{1'b1, 4'd3, 2'b10, 1'b0, 4'd3, 1'b0, 16'h0008}, // R4 close q3
    '{1'b1, 4'd5, 2'b10, 1'b0, 4'd5, 1'b0, 16'h0008}, // R5 orphan end q5
    '{1'b1, 4'd5, 2'b11, 1'b0, 4'd5, 1'b0, 16'h0028}, // R4 single-word packet
    '{1'b1, 4'd0, 2'b01, 1'b0, 4'd0, 1'b0, 16'h0028}, // R3 open q0
    '{1'b1, 4'd0, 2'b01, 1'b0, 4'd0, 1'b0, 16'h0028}, // R3 restart q0
    '{1'b1, 4'd0, 2'b10, 1'b0, 4'd0, 1'b0, 16'h0029}, // R4 close q0
    '{1'b0, 4'd0, 2'b00, 1'b1, 4'd3, 1'b0, 16'h0029}, // R6 read without end
    '{1'b0, 4'd0, 2'b00, 1'b1, 4'd3, 1'b1, 16'h0021}, // R6 read end q3
    '{1'b1, 4'd5, 2'b01, 1'b1, 4'd5, 1'b1, 16'h0001}, // R6 open and retire q5
    '{1'b1, 4'd5, 2'b10, 1'b0, 4'd5, 1'b0, 16'h0021}, // R4 close q5
    '{1'b1, 4'd0, 2'b01, 1'b0, 4'd0, 1'b0, 16'h0021}, // R3 open q0
    '{1'b1, 4'd0, 2'b10, 1'b1, 4'd0, 1'b1, 16'h0021}, // R8 same-cycle q0
    '{1'b0, 4'd0, 2'b00, 1'b1, 4'd0, 1'b1, 16'h0020}, // R6 retire q0
    '{1'b0, 4'd0, 2'b00, 1'b1, 4'd0, 1'b1, 16'h0020}, // R7 read end at zero
    '{1'b1, 4'd0, 2'b11, 1'b0, 4'd0, 1'b0, 16'h0021}  // R7 no wrap below zero
  };

  task automatic chk(input string req, input logic [NQ-1:0] act, input logic [NQ-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; rdEn = 0; rdEop = 0; prstEn = 0; wrMark = '0;
  endtask

  // drive at falling edge, let one rising edge pass, sample at next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int q, input logic [1:0] mk);
    wrEn = 1; wrQ = QW'(q); wrMark = mk;
  endtask

  task automatic rd(input int q, input logic eop);
    rdEn = 1; rdQ = QW'(q); rdEop = eop;
  endtask

  initial begin
    @(negedge clk);
    // R13 reset state
    chk("R13 vec in reset", readyVec, '0);
    chk("R13 flag in reset", {15'd0, pktReady}, '0);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      idle();
      wrEn = TABLE[i].wEn; wrQ = TABLE[i].wQ; wrMark = TABLE[i].wMk;
      rdEn = TABLE[i].rEn; rdQ = TABLE[i].rQ; rdEop = TABLE[i].rEop;
      step();
      idle();
      chk($sformatf("R11 row %0d vec", i), readyVec, TABLE[i].expVec);
      chk($sformatf("R11 row %0d flag", i), {15'd0, pktReady}, {15'd0, TABLE[i].expVec[TABLE[i].rQ]});
      chk($sformatf("R12 row %0d bus", i), statusBus, TABLE[i].expVec);
    end

    // R10 partial reset beats a same-cycle completion on q5
    idle(); prstEn = 1; prstQ = 4'd5; wr(5, 2'b11); step(); idle();
    chk("R10 clear wins", readyVec, 16'h0001);
    // R10 partial reset drops the open packet
    wr(5, 2'b01); step(); idle();
    prstEn = 1; prstQ = 4'd5; step(); idle();
    wr(5, 2'b10); step(); idle();
    chk("R10 open state cleared", readyVec, 16'h0001);

    // R9 saturation at 3 on q9
    for (int k = 0; k < 5; k++) begin wr(9, 2'b11); step(); end
    idle();
    for (int k = 0; k < 2; k++) begin rd(9, 1'b1); step(); end
    idle(); rdQ = 4'd9;
    #1 chk("R9 still one left", {15'd0, pktReady}, 16'd1);
    rd(9, 1'b1); step(); idle();
    chk("R9 saturated count drained", {15'd0, pktReady}, 16'd0);
    chk("R9 vector", readyVec, 16'h0001);

    // R1 narrow read port disables packet mode
    rdPortWide = 0; rdQ = 4'd0;
    #1 chk("R1 bus passthrough", statusBus, 16'hA5C3);
    chk("R1 vec forced low", readyVec, '0);
    chk("R1 flag forced low", {15'd0, pktReady}, '0);
    wr(7, 2'b11); step(); idle();
    wr(0, 2'b01); step(); idle();       // start ignored while off
    rdPortWide = 1;
    #1 chk("R1 writes ignored while off", readyVec, 16'h0001);
    chk("R12 bus back to ready bits", statusBus, 16'h0001);
    wr(0, 2'b10); step(); idle();       // orphan end: q0 stays at one
    rd(0, 1'b1); step(); idle();
    chk("R5 orphan after off start", readyVec, 16'h0000);
    modeReq = 0;
    #1 chk("R1 mode request low", statusBus, 16'hA5C3);
    modeReq = 1;

    // R2 end marker alone on bit 1, start alone on bit 0
    wr(12, 2'b01); step(); idle();
    chk("R2 start alone", readyVec, 16'h0000);
    wr(12, 2'b10); step(); idle();
    chk("R2 end closes", readyVec, 16'h1000);

    // R13 reset mid-run
    rstN = 0;
    #1 chk("R13 async clear", readyVec, '0);
    step(); rstN = 1; step();
    chk("R13 after release", readyVec, '0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule